// File: doc/BRIEF.md
# Multicycle Instruction Step Sequencer

This block is the finite-state controller of a 32-bit load/store processor whose datapath has a single memory for instructions and data, one ALU, and holding registers between cycles. It takes the 6-bit operation code held in the instruction register and steps each instruction through a short sequence of one-cycle phases: fetch, decode, then execute, memory access and register write-back as the instruction needs them. In every phase it drives the complete set of datapath selects and write enables. Different instructions therefore take different numbers of cycles.

Because the memory and the ALU are shared across the phases of an instruction, every phase picks the memory address source and both ALU operand sources. The controller supports register-register operations, word load, word store, branch on equal and unconditional jump. Any other code is abandoned after decode. The control outputs are a pure function of the current phase, and the phase register is the only state. There is no data stream at the edge of the block, so every pin is a plain level with no handshake.

Top module: `mcs_sequencer`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the phase is fetch. A reset that arrives in the middle of an instruction abandons it at once.
- R2: The fetch phase drives mem_rd=1, ir_load=1, addr_data=0, opa_reg=0, opb_sel=01 (constant 4), alu_mode=00 (add), pc_sel=00 (ALU result) and pc_load=1. All other outputs are 0.
- R3: Decode follows every fetch. It drives opa_reg=0, opb_sel=11 (offset shifted left by 2) and alu_mode=00, with every enable 0. This produces the branch target.
- R4: Opcode 000000 (register-register) takes 4 cycles. The third cycle drives opa_reg=1, opb_sel=00 (B register) and alu_mode=10 (use function field). The fourth cycle drives rf_wr=1 and rf_dst_rd=1 with wb_mem=0.
- R5: Opcode 100011 (load) takes 5 cycles. The third cycle drives opa_reg=1, opb_sel=10 (sign-extended offset) and alu_mode=00. The fourth drives mem_rd=1 and addr_data=1. The fifth drives rf_wr=1 and wb_mem=1 with rf_dst_rd=0.
- R6: Opcode 101011 (store) takes 4 cycles. The third cycle is the same as for load. The fourth drives mem_wr=1 and addr_data=1.
- R7: Opcode 000100 (branch on equal) takes 3 cycles. The third cycle drives opa_reg=1, opb_sel=00, alu_mode=01 (subtract), pc_sel=01 (ALU-output register) and pc_cond=1.
- R8: Opcode 000010 (jump) takes 3 cycles. The third cycle drives pc_sel=10 (jump target) and pc_load=1.
- R9: Any other opcode takes 2 cycles (fetch, decode) and asserts no memory, register, PC or instruction-register enable after fetch.
- R10: Memory read and memory write are never high in the same cycle. The data address (addr_data=1) is selected only during a data access.
- R11: The cycle after every completing phase is a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Operation field of the instruction register |
| mem_rd | output | 1 | Shared memory read enable |
| mem_wr | output | 1 | Shared memory write enable |
| wb_mem | output | 1 | Register write data from memory-data register (1) or ALU-output register (0) |
| ir_load | output | 1 | Instruction register write enable |
| pc_sel | output | 2 | Next PC: 00 ALU result, 01 ALU-output register, 10 jump target |
| alu_mode | output | 2 | 00 add, 01 subtract, 10 use function field |
| opb_sel | output | 2 | ALU operand B: 00 B register, 01 constant 4, 10 offset, 11 offset shifted by 2 |
| opa_reg | output | 1 | ALU operand A: 0 PC, 1 A register |
| rf_wr | output | 1 | Register file write enable |
| rf_dst_rd | output | 1 | Destination register from rd field (1) or rt field (0) |
| addr_data | output | 1 | Memory address from ALU-output register (1) or PC (0) |
| pc_cond | output | 1 | PC write when ALU result is zero |
| pc_load | output | 1 | Unconditional PC write |

## Verification
On every cycle, the assertions check these properties: the two memory enables never overlap, the data address appears only during a data access, decode never touches memory or state after a fetch, a memory write-back is preceded by a data read, and every completing phase is followed by a fetch. Only the bench scenarios can show the exact control vector in each phase of each instruction class, and the number of cycles each class takes. This covers all 64 opcode values, including the unused ones that must give up after decode. The scenarios also check that a reset in the middle of a load abandons it.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int OPC_W = 6;

  typedef enum logic [3:0] {
    PH_FETCH, PH_DECODE, PH_ADDR, PH_RCALC, PH_BRANCH,
    PH_JUMP, PH_LDMEM, PH_STMEM, PH_RWB, PH_LDWB
  } phase_t;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       wb_mem;
    logic       ir_load;
    logic [1:0] pc_sel;
    logic [1:0] alu_mode;
    logic [1:0] opb_sel;
    logic       opa_reg;
    logic       rf_wr;
    logic       rf_dst_rd;
    logic       addr_data;
    logic       pc_cond;
    logic       pc_load;
  } ctrl_t;

  localparam logic [1:0] ALU_ADD = 2'b00;
  localparam logic [1:0] ALU_SUB = 2'b01;
  localparam logic [1:0] ALU_FN  = 2'b10;
  localparam logic [1:0] OPB_REG = 2'b00;
  localparam logic [1:0] OPB_4   = 2'b01;
  localparam logic [1:0] OPB_OFS = 2'b10;
  localparam logic [1:0] OPB_OSH = 2'b11;
  localparam logic [1:0] PCS_ALU = 2'b00;
  localparam logic [1:0] PCS_OUT = 2'b01;
  localparam logic [1:0] PCS_JMP = 2'b10;
endpackage

// File: rtl/mcs_next_phase.sv
module mcs_next_phase
  import mcs_pkg::*;
#(
  parameter int         OW       = OPC_W,
  parameter logic [5:0] OP_RTYPE = 6'b000000,
  parameter logic [5:0] OP_LOAD  = 6'b100011,
  parameter logic [5:0] OP_STORE = 6'b101011,
  parameter logic [5:0] OP_BEQ   = 6'b000100,
  parameter logic [5:0] OP_JUMP  = 6'b000010
) (
  input  phase_t        cur,
  input  logic [OW-1:0] opcode,
  output phase_t        nxt
);
  always_comb begin
    nxt = PH_FETCH;
    unique case (cur)
      PH_FETCH:  nxt = PH_DECODE;
      PH_DECODE: begin
        if      (opcode == OW'(OP_RTYPE)) nxt = PH_RCALC;
        else if (opcode == OW'(OP_LOAD))  nxt = PH_ADDR;
        else if (opcode == OW'(OP_STORE)) nxt = PH_ADDR;
        else if (opcode == OW'(OP_BEQ))   nxt = PH_BRANCH;
        else if (opcode == OW'(OP_JUMP))  nxt = PH_JUMP;
        else                              nxt = PH_FETCH;
      end
      PH_ADDR:   nxt = (opcode == OW'(OP_LOAD)) ? PH_LDMEM : PH_STMEM;
      PH_RCALC:  nxt = PH_RWB;
      PH_LDMEM:  nxt = PH_LDWB;
      default:   nxt = PH_FETCH;
    endcase
  end
endmodule

// File: rtl/mcs_ctrl_decode.sv
module mcs_ctrl_decode
  import mcs_pkg::*;
(
  input  phase_t cur,
  output ctrl_t  ctl
);
  always_comb begin
    ctl = '0;
    unique case (cur)
      PH_FETCH: begin
        ctl.mem_rd   = 1'b1;
        ctl.ir_load  = 1'b1;
        ctl.opb_sel  = OPB_4;
        ctl.alu_mode = ALU_ADD;
        ctl.pc_sel   = PCS_ALU;
        ctl.pc_load  = 1'b1;
      end
      PH_DECODE: ctl.opb_sel = OPB_OSH;
      PH_ADDR: begin
        ctl.opa_reg = 1'b1;
        ctl.opb_sel = OPB_OFS;
      end
      PH_RCALC: begin
        ctl.opa_reg  = 1'b1;
        ctl.opb_sel  = OPB_REG;
        ctl.alu_mode = ALU_FN;
      end
      PH_BRANCH: begin
        ctl.opa_reg  = 1'b1;
        ctl.alu_mode = ALU_SUB;
        ctl.pc_sel   = PCS_OUT;
        ctl.pc_cond  = 1'b1;
      end
      PH_JUMP: begin
        ctl.pc_sel  = PCS_JMP;
        ctl.pc_load = 1'b1;
      end
      PH_LDMEM: begin
        ctl.mem_rd    = 1'b1;
        ctl.addr_data = 1'b1;
      end
      PH_STMEM: begin
        ctl.mem_wr    = 1'b1;
        ctl.addr_data = 1'b1;
      end
      PH_RWB: begin
        ctl.rf_wr     = 1'b1;
        ctl.rf_dst_rd = 1'b1;
      end
      PH_LDWB: begin
        ctl.rf_wr  = 1'b1;
        ctl.wb_mem = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
  import mcs_pkg::*;
#(
  parameter int         OW       = OPC_W,
  parameter logic [5:0] OP_RTYPE = 6'b000000,
  parameter logic [5:0] OP_LOAD  = 6'b100011,
  parameter logic [5:0] OP_STORE = 6'b101011,
  parameter logic [5:0] OP_BEQ   = 6'b000100,
  parameter logic [5:0] OP_JUMP  = 6'b000010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [OW-1:0] opcode,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          wb_mem,
  output logic          ir_load,
  output logic [1:0]    pc_sel,
  output logic [1:0]    alu_mode,
  output logic [1:0]    opb_sel,
  output logic          opa_reg,
  output logic          rf_wr,
  output logic          rf_dst_rd,
  output logic          addr_data,
  output logic          pc_cond,
  output logic          pc_load
);
  phase_t phase_q, phase_d;
  ctrl_t  ctl;

  mcs_next_phase #(
    .OW(OW), .OP_RTYPE(OP_RTYPE), .OP_LOAD(OP_LOAD),
    .OP_STORE(OP_STORE), .OP_BEQ(OP_BEQ), .OP_JUMP(OP_JUMP)
  ) u_next (
    .cur(phase_q), .opcode(opcode), .nxt(phase_d)
  );

  mcs_ctrl_decode u_dec (.cur(phase_q), .ctl(ctl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_FETCH;
    else        phase_q <= phase_d;
  end

  assign mem_rd    = ctl.mem_rd;
  assign mem_wr    = ctl.mem_wr;
  assign wb_mem    = ctl.wb_mem;
  assign ir_load   = ctl.ir_load;
  assign pc_sel    = ctl.pc_sel;
  assign alu_mode  = ctl.alu_mode;
  assign opb_sel   = ctl.opb_sel;
  assign opa_reg   = ctl.opa_reg;
  assign rf_wr     = ctl.rf_wr;
  assign rf_dst_rd = ctl.rf_dst_rd;
  assign addr_data = ctl.addr_data;
  assign pc_cond   = ctl.pc_cond;
  assign pc_load   = ctl.pc_load;

  p_mem_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_data_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_data |-> (!ir_load && (mem_rd || mem_wr)));

  p_decode_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> (!ir_load && !mem_rd && !mem_wr && !rf_wr && !pc_load
                 && !pc_cond && opb_sel == OPB_OSH));

  p_load_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_mem |-> $past(mem_rd && addr_data));

  p_back_to_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr || mem_wr || pc_cond || (pc_load && !ir_load)) |=> ir_load);
endmodule

// File: tb/tb_mcs_sequencer.sv
module tb_mcs_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = '0;
  logic       mem_rd, mem_wr, wb_mem, ir_load, opa_reg, rf_wr, rf_dst_rd;
  logic       addr_data, pc_cond, pc_load;
  logic [1:0] pc_sel, alu_mode, opb_sel;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  mcs_sequencer dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_mem(wb_mem), .ir_load(ir_load),
    .pc_sel(pc_sel), .alu_mode(alu_mode), .opb_sel(opb_sel),
    .opa_reg(opa_reg), .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd),
    .addr_data(addr_data), .pc_cond(pc_cond), .pc_load(pc_load)
  );

  function automatic logic [15:0] mk(bit mrd, bit mwr, bit mtr, bit irl,
      logic [1:0] pcs, logic [1:0] aop, logic [1:0] bs, bit as, bit rw,
      bit rd, bit ad, bit pc_c, bit pc_l);
    return {mrd, mwr, mtr, irl, pcs, aop, bs, as, rw, rd, ad, pc_c, pc_l};
  endfunction

  function automatic logic [15:0] actual();
    return {mem_rd, mem_wr, wb_mem, ir_load, pc_sel, alu_mode, opb_sel,
            opa_reg, rf_wr, rf_dst_rd, addr_data, pc_cond, pc_load};
  endfunction

  localparam logic [15:0] V_FETCH = mk(1,0,0,1,2'd0,2'd0,2'd1,0,0,0,0,0,1);
  localparam logic [15:0] V_DEC   = mk(0,0,0,0,2'd0,2'd0,2'd3,0,0,0,0,0,0);
  localparam logic [15:0] V_ADDR  = mk(0,0,0,0,2'd0,2'd0,2'd2,1,0,0,0,0,0);
  localparam logic [15:0] V_RCALC = mk(0,0,0,0,2'd0,2'd2,2'd0,1,0,0,0,0,0);
  localparam logic [15:0] V_RWB   = mk(0,0,0,0,2'd0,2'd0,2'd0,0,1,1,0,0,0);
  localparam logic [15:0] V_LDMEM = mk(1,0,0,0,2'd0,2'd0,2'd0,0,0,0,1,0,0);
  localparam logic [15:0] V_LDWB  = mk(0,0,1,0,2'd0,2'd0,2'd0,0,1,0,0,0,0);
  localparam logic [15:0] V_STMEM = mk(0,1,0,0,2'd0,2'd0,2'd0,0,0,0,1,0,0);
  localparam logic [15:0] V_BEQ   = mk(0,0,0,0,2'd1,2'd1,2'd0,1,0,0,0,1,0);
  localparam logic [15:0] V_JMP   = mk(0,0,0,0,2'd2,2'd0,2'd0,0,0,0,0,0,1);

  function automatic int n_cyc(int op);
    case (op)
      0:  return 4;
      35: return 5;
      43: return 4;
      4:  return 3;
      2:  return 3;
      default: return 2;
    endcase
  endfunction

  function automatic logic [15:0] exp_vec(int op, int s);
    if (s == 0) return V_FETCH;
    if (s == 1) return V_DEC;
    case (op)
      0:  return (s == 2) ? V_RCALC : V_RWB;
      35: return (s == 2) ? V_ADDR : ((s == 3) ? V_LDMEM : V_LDWB);
      43: return (s == 2) ? V_ADDR : V_STMEM;
      4:  return V_BEQ;
      2:  return V_JMP;
      default: return V_FETCH;
    endcase
  endfunction

  function automatic string req_of(int op, int s);
    if (s == 0) return "R2";
    if (s == 1) return "R3";
    case (op)
      0: return "R4"; 35: return "R5"; 43: return "R6";
      4: return "R7"; 2: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R1", actual(), V_FETCH);
    rst_n = 1'b1;
    #1 check("R1", actual(), V_FETCH);
    // Sweep every opcode value; each pass starts at a fetch cycle.
    for (int op = 0; op < 64; op++) begin
      opcode = op[5:0];
      for (int s = 0; s < n_cyc(op); s++) begin
        check(req_of(op, s), actual(), exp_vec(op, s));
        @(posedge clk);
        @(negedge clk);
      end
      // Cycle count per class: next phase must be fetch (R11)
      check("R11", {15'd0, ir_load}, 16'd1);
    end
    // Mid-instruction reset during the load memory step (R1)
    opcode = 6'b100011;
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
    end
    check("R5", actual(), V_LDMEM);
    rst_n = 1'b0;
    #1 check("R1", actual(), V_FETCH);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1", actual(), V_FETCH);
    @(posedge clk);
    @(negedge clk);
    check("R3", actual(), V_DEC);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule